// File: doc/BRIEF.md
# Debug Address Watchpoint Unit

The unit watches every processor access against four programmable address slots. Each slot has an enable bit, a length code that sets how many bytes it watches, and a mode code that selects which access kinds can fire it: instruction fetch, data write, or any data access. When an enabled slot sees a matching access, the unit raises a one-cycle debug-exception pulse. It also sets that slot's bit in a sticky status register, so that a handler can find out what caused the trap.

Software programs the slots and the control word, and reads or clears the status, through a flat register port. Writes take effect on the clock edge and reads are combinational. A separate single-step input shares the same exception pulse and has its own status bit. For a fetch match, the unit captures the address of the instruction that was about to run, not the address of the one after it.

Top module: `dbg_watch_unit`

## Requirements
- R1: A slot whose enable bit (control bit n for slot n) is clear never matches, whatever its address, mode or length.
- R2: Length code (control bits 10+4n and 11+4n): 00 watches 1 byte, 01 watches 2, 11 watches 4, 10 watches 8. The watched range starts at the slot address with the low log2(length) bits cleared.
- R3: Mode code (control bits 8+4n and 9+4n): 00 fires on fetches only, 01 on data writes only, 11 on data reads or writes. Access kind is 00 fetch, 01 write, 10 read. An access covers 2^acc_size bytes from acc_addr and matches when any of its bytes falls inside the watched range.
- R4: Mode code 10 never matches.
- R5: Register offsets are 0 to 3 for slots 0 to 3 (read back zero-extended), 6 for status and 7 for control. Offsets 4 and 5 read as zero and ignore writes.
- R6: A control write keeps only the enable, mode and length bits (mask 0x00FFFF0F). Every other bit reads back as zero.
- R7: A matching access sets the status bit of every matching slot (bit n for slot n) on the next clock edge. In the same edge, dbg_exc goes high for exactly one cycle, even when several slots match together.
- R8: A step_done pulse sets status bit 4 and raises dbg_exc on the next edge.
- R9: Status bits are sticky. A status write clears each bit whose written value is 0 and leaves the others unchanged. A hardware set in the same cycle takes priority over the clear.
- R10: On a slot match, dbg_addr captures the access address, so a fetch trap reports the fetch address itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| acc_valid | input | 1 | Processor access present this cycle |
| acc_kind | input | 2 | 00 fetch, 01 write, 10 read |
| acc_addr | input | ADDR_W | Access start address |
| acc_size | input | 2 | log2 of access byte count |
| step_done | input | 1 | Single-step completion pulse |
| dbg_exc | output | 1 | One-cycle debug exception pulse |
| dbg_addr | output | ADDR_W | Address of the last matching access |

## Verification
A wrong alignment mask or length decode shows up one edge after the access: either dbg_exc is missing for a byte just inside the watched window, or it fires for a byte just outside it. The bench therefore sweeps accesses across both edges of the window for every length, mode, access kind and access size. A status register that loses or invents bits can be seen by reading offset 6 on the cycle after the pulse. A corrupted control mask can be seen as soon as the control word is read back.

// File: rtl/dbg_watch_pkg.sv
package dbg_watch_pkg;
  localparam int NSLOT = 4;
  localparam int REG_W = 32;
  localparam int NSTAT = NSLOT + 1;

  localparam logic [1:0] ACC_FETCH = 2'b00;
  localparam logic [1:0] ACC_WRITE = 2'b01;
  localparam logic [1:0] ACC_READ  = 2'b10;

  localparam logic [1:0] MODE_EXEC = 2'b00;
  localparam logic [1:0] MODE_WR   = 2'b01;
  localparam logic [1:0] MODE_RSV  = 2'b10;
  localparam logic [1:0] MODE_RW   = 2'b11;

  localparam logic [2:0] OFS_STATUS = 3'd6;
  localparam logic [2:0] OFS_CTRL   = 3'd7;

  // watched byte count for a slot length code (note 10 -> 8, 11 -> 4)
  function automatic logic [3:0] len_bytes(input logic [1:0] code);
    case (code)
      2'b00:   return 4'd1;
      2'b01:   return 4'd2;
      2'b10:   return 4'd8;
      default: return 4'd4;
    endcase
  endfunction

  function automatic logic [3:0] acc_bytes(input logic [1:0] sz);
    return 4'd1 << sz;
  endfunction

  function automatic logic [REG_W-1:0] ctrl_mask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < NSLOT; i++) begin
      m[i] = 1'b1;
      m[8+4*i +: 4] = 4'hF;
    end
    return m;
  endfunction
endpackage

// File: rtl/dbg_slot_cmp.sv
module dbg_slot_cmp
  import dbg_watch_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [1:0]        mode,
  input  logic [1:0]        len_code,
  input  logic [ADDR_W-1:0] slot_addr,
  input  logic              acc_valid,
  input  logic [1:0]        acc_kind,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_size,
  output logic              hit
);
  localparam int PADW = ADDR_W - 3;

  logic [ADDR_W-1:0] low_mask;
  logic [ADDR_W:0]   win_lo, win_hi, a_lo, a_hi;
  logic              kind_ok, overlap;

  always_comb begin
    low_mask = ADDR_W'(len_bytes(len_code) - 4'd1);
    win_lo   = {1'b0, slot_addr & ~low_mask};
    win_hi   = win_lo + {{PADW{1'b0}}, len_bytes(len_code) - 4'd1};
    a_lo     = {1'b0, acc_addr};
    a_hi     = a_lo + {{PADW{1'b0}}, acc_bytes(acc_size) - 4'd1};
    overlap  = (a_lo <= win_hi) && (win_lo <= a_hi);
    case (mode)
      MODE_EXEC: kind_ok = (acc_kind == ACC_FETCH);
      MODE_WR:   kind_ok = (acc_kind == ACC_WRITE);
      MODE_RW:   kind_ok = (acc_kind == ACC_WRITE) || (acc_kind == ACC_READ);
      default:   kind_ok = 1'b0;
    endcase
    hit = en && acc_valid && kind_ok && overlap;
  end

  AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !hit); // R1
  AST_RSV_MODE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_RSV) |-> !hit); // R4
endmodule

// File: rtl/dbg_status_reg.sv
module dbg_status_reg #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] set,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (wr) q <= (q & wdata) | set;
    else         q <= q | set;
  end

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> ((q & $past(q)) == $past(q))); // R9
  AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (set != '0) |=> ((q & $past(set)) == $past(set))); // R7
endmodule

// File: rtl/dbg_watch_unit.sv
module dbg_watch_unit
  import dbg_watch_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              acc_valid,
  input  logic [1:0]        acc_kind,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_size,
  input  logic              step_done,
  output logic              dbg_exc,
  output logic [ADDR_W-1:0] dbg_addr
);
  localparam logic [REG_W-1:0] CMASK = ctrl_mask();

  logic [ADDR_W-1:0] slot_q [NSLOT];
  logic [REG_W-1:0]  ctrl_q;
  logic [NSLOT-1:0]  slot_hit;
  logic              any_hit;
  logic [NSTAT-1:0]  status_q;
  logic              status_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      for (int i = 0; i < NSLOT; i++) slot_q[i] <= '0;
    end else if (reg_we) begin
      if (reg_addr == OFS_CTRL) ctrl_q <= reg_wdata & CMASK;
      for (int i = 0; i < NSLOT; i++)
        if (reg_addr == 3'(i)) slot_q[i] <= reg_wdata[ADDR_W-1:0];
    end
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    dbg_slot_cmp #(.ADDR_W(ADDR_W)) u_cmp (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (ctrl_q[g]),
      .mode     (ctrl_q[8+4*g +: 2]),
      .len_code (ctrl_q[10+4*g +: 2]),
      .slot_addr(slot_q[g]),
      .acc_valid(acc_valid),
      .acc_kind (acc_kind),
      .acc_addr (acc_addr),
      .acc_size (acc_size),
      .hit      (slot_hit[g])
    );
  end

  assign any_hit   = |slot_hit;
  assign status_wr = reg_we && (reg_addr == OFS_STATUS);

  dbg_status_reg #(.W(NSTAT)) u_status (
    .clk  (clk),
    .rst_n(rst_n),
    .wr   (status_wr),
    .wdata(reg_wdata[NSTAT-1:0]),
    .set  ({step_done, slot_hit}),
    .q    (status_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dbg_exc  <= 1'b0;
      dbg_addr <= '0;
    end else begin
      dbg_exc <= any_hit || step_done;
      if (any_hit) dbg_addr <= acc_addr;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr < 3'(NSLOT)) reg_rdata = REG_W'(slot_q[reg_addr[1:0]]);
    else if (reg_addr == OFS_STATUS) reg_rdata = REG_W'(status_q);
    else if (reg_addr == OFS_CTRL) reg_rdata = ctrl_q;
  end

  AST_CTRL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == OFS_CTRL) |=> (ctrl_q == ($past(reg_wdata) & CMASK))); // R6
  AST_EXC_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_exc |-> (status_q != '0)); // R7
  AST_ADDR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |=> (dbg_addr == $past(acc_addr))); // R10
endmodule

// File: tb/dbg_watch_unit_tb.sv
`timescale 1ns/1ps
module dbg_watch_unit_tb;
  localparam int AW = 16;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          reg_we = 0;
  logic [2:0]    reg_addr = 0;
  logic [31:0]   reg_wdata = 0;
  logic [31:0]   reg_rdata;
  logic          acc_valid = 0;
  logic [1:0]    acc_kind = 0;
  logic [AW-1:0] acc_addr = 0;
  logic [1:0]    acc_size = 0;
  logic          step_done = 0;
  logic          dbg_exc;
  logic [AW-1:0] dbg_addr;

  int nvec = 0, nfail = 0;

  always #5 clk = ~clk;

  dbg_watch_unit #(.ADDR_W(AW)) u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic access(input logic [1:0] k, input logic [AW-1:0] a, input logic [1:0] s);
    @(negedge clk); acc_valid = 1; acc_kind = k; acc_addr = a; acc_size = s;
    @(negedge clk); acc_valid = 0;
  endtask

  function automatic logic [31:0] cword(input int s, input bit en, input logic [1:0] md, input logic [1:0] ln);
    return (32'(en) << s) | (32'(md) << (8 + 4*s)) | (32'(ln) << (10 + 4*s));
  endfunction

  // reference: byte-by-byte membership test
  function automatic bit ref_hit(input int sa, input logic [1:0] ln, input logic [1:0] md,
                                 input logic [1:0] k, input int a, input logic [1:0] s);
    int span;
    bit kind_ok;
    case (ln) 2'b00: span = 1; 2'b01: span = 2; 2'b10: span = 8; default: span = 4; endcase
    kind_ok = (md == 2'b00 && k == 2'b00) || (md == 2'b01 && k == 2'b01) ||
              (md == 2'b11 && (k == 2'b01 || k == 2'b10));
    if (!kind_ok) return 0;
    for (int b = 0; b < (1 << s); b++)
      if (((a + b) / span) == (sa / span)) return 1;
    return 0;
  endfunction

  initial begin
    #2_000_000;
    nfail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R5 reset state: all offsets zero
    for (int o = 0; o < 8; o++) begin rd(3'(o), d); chk("R5 reset read", d, 0); end
    chk("R7 reset exc", 32'(dbg_exc), 0);

    // R6 control masking
    wr(3'd7, 32'hFFFF_FFFF); rd(3'd7, d); chk("R6 mask ones", d, 32'h00FF_FF0F);
    wr(3'd7, 32'hA5A5_A5A5); rd(3'd7, d); chk("R6 mask pattern", d, 32'hA5A5_A5A5 & 32'h00FF_FF0F);

    // R5 slot readback, unused offsets
    wr(3'd1, 32'hFFFF_1234); rd(3'd1, d); chk("R5 slot1 zero-ext", d, 32'h0000_1234);
    wr(3'd4, 32'hDEAD_BEEF); wr(3'd5, 32'hDEAD_BEEF);
    rd(3'd4, d); chk("R5 offset4 zero", d, 0);
    rd(3'd5, d); chk("R5 offset5 zero", d, 0);
    rd(3'd0, d); chk("R5 slot0 untouched", d, 0);

    // R1 disabled slot
    wr(3'd0, 32'h200); wr(3'd7, cword(0, 0, 2'b11, 2'b00));
    wr(3'd6, 0);
    access(2'b10, 16'h200, 2'd0);
    chk("R1 disabled exc", 32'(dbg_exc), 0);
    rd(3'd6, d); chk("R1 disabled status", d, 0);

    // R7 all slots hit together
    for (int s = 0; s < 4; s++) wr(3'(s), 32'h300);
    wr(3'd7, cword(0,1,2'b11,2'b00) | cword(1,1,2'b11,2'b00) | cword(2,1,2'b11,2'b00) | cword(3,1,2'b11,2'b00));
    access(2'b01, 16'h300, 2'd0);
    chk("R7 multi exc", 32'(dbg_exc), 1);
    rd(3'd6, d); chk("R7 multi status", d, 32'hF);
    chk("R7 single pulse", 32'(dbg_exc), 0);

    // R8 single step
    @(negedge clk); step_done = 1; @(negedge clk); step_done = 0;
    chk("R8 step exc", 32'(dbg_exc), 1);
    rd(3'd6, d); chk("R8 step status", d, 32'h1F);

    // R9 sticky, write-zero clears
    wr(3'd6, 32'hFFFF_FFFF); rd(3'd6, d); chk("R9 write ones keeps", d, 32'h1F);
    wr(3'd6, 32'h0F); rd(3'd6, d); chk("R9 partial clear", d, 32'h0F);
    @(negedge clk); reg_we = 1; reg_addr = 3'd6; reg_wdata = 0; step_done = 1;
    @(negedge clk); reg_we = 0; step_done = 0;
    rd(3'd6, d); chk("R9 set beats clear", d, 32'h10);

    // R10 fetch trap reports the fetch address
    wr(3'd2, 32'h400); wr(3'd7, cword(2, 1, 2'b00, 2'b00)); wr(3'd6, 0);
    access(2'b00, 16'h400, 2'd0);
    chk("R10 exc", 32'(dbg_exc), 1);
    chk("R10 addr", 32'(dbg_addr), 32'h400);

    // R2 R3 R4 sweep
    for (int si = 0; si < 2; si++)
      for (int ln = 0; ln < 4; ln++)
        for (int md = 0; md < 4; md++)
          for (int k = 0; k < 3; k++)
            for (int sz = 0; sz < 4; sz++)
              for (int off = 0; off < 20; off++) begin
                int s, sa, a;
                bit e;
                s  = (ln + md + off) % 4;
                sa = (si == 0) ? 32'h105 : 32'h10C;
                a  = 32'h0F8 + off;
                wr(3'(s), 32'(sa));
                wr(3'd7, cword(s, 1, 2'(md), 2'(ln)));
                wr(3'd6, 0);
                access(2'(k), AW'(a), 2'(sz));
                e = ref_hit(sa, 2'(ln), 2'(md), 2'(k), a, 2'(sz));
                chk(md == 2 ? "R4 mode10 exc" : "R2 R3 exc", 32'(dbg_exc), 32'(e));
                if (e) chk("R10 sweep addr", 32'(dbg_addr), 32'(a));
                rd(3'd6, d);
                chk("R2 R3 status", d, e ? (32'd1 << s) : 32'd0);
              end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule